// File: doc/BRIEF.md
# SPI NOR Flash Erase Sequencer

This block clears a byte range of a serial NOR flash that hangs off a four-wire SPI bus. The host gives a start address, a byte length and a flag that says whether the flash supports uniform 4 KiB erase units, then pulses `start_i`. The block then runs the whole erase loop in hardware. For each unit it reads the flash status until the device reports idle. It then sends a write-enable command, followed by one erase command for that unit. It moves the address on by the unit size and repeats until the range is used up. After the last erase it polls again, so that completion means the flash has actually finished.

The unit size depends on the flag. With the flag set, the block uses 4 KiB units and the small-erase opcode. With the flag clear, it uses the large-sector opcode, and the unit is a build-time power of two, normally 64 KiB. A range whose start or length does not fall on a unit boundary is refused before any bus activity. A programmable bound on consecutive busy status reads stops a flash that never goes idle. The block reports the end of every job with a one-cycle done pulse that carries an error flag.

Top module: `nor_erase_seq`

## Requirements
- R1: Before every erase, and once more after the last one, the block reads the status register with opcode 0x05 followed by one dummy byte. It repeats the read until bit 0 of the returned byte (write in progress) is 0. No erase is issued while that bit is 1.
- R2: Exactly one write-enable command is sent before every erase command. It is the single byte 0x06, framed by its own chip-select low period.
- R3: With `small_i` high at start, every erase opcode is 0x20 and the address advances by 4096 per erase.
- R4: With `small_i` low at start, every erase opcode is 0xD8 and the address advances by 2^LARGE_LOG2 per erase.
- R5: An erase frame is exactly four bytes: the opcode, then address bits 23:16, 15:8 and 7:0. Every byte is sent MSB first.
- R6: A job issues exactly len/unit erases. The erases go to start, start+unit, start+2·unit and so on, in rising order.
- R7: `cs_n_o` stays low for the whole of one command and goes high between commands. SCLK stays low whenever `cs_n_o` is high, and `cs_n_o` changes only while SCLK is low.
- R8: The bus runs in SPI mode 0. SCLK idles low, MISO is sampled on the rising edge, and MOSI changes only while SCLK is low.
- R9: If the start address or the length is not a multiple of the selected unit, the block gives done with error set. Chip select never goes low in that job.
- R10: When the count of consecutive busy status reads reaches `poll_limit_i` (0 acts as 1), the job ends with done and error, and no further command is sent.
- R11: `done_o` is a single-cycle pulse, and `err_o` is valid only while `done_o` is high. `busy_o` is high from the accepted start until done. A start pulse while busy has no effect. A zero length ends at once with no error and no bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| addr_i | input | 24 | Byte address where the erase begins |
| len_i | input | LEN_W | Number of bytes to erase |
| small_i | input | 1 | 1 selects 4 KiB units, 0 selects large sectors |
| poll_limit_i | input | TMO_W | Consecutive busy status reads allowed before error |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error qualifier, valid with done_o |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |
| cs_n_o | output | 1 | SPI chip select, active low |

## Verification
The bound checker watches the bus framing and the handshake on every cycle:
- SCLK stays quiet while chip select is high, and chip select moves only while SCLK is low.
- MOSI holds steady across each high phase of SCLK.
- Done is a single pulse, and an error appears only together with done.
- Chip select is low only while the block is busy.

Other properties depend on what a flash answers and on whole command streams, so only the bench scenarios show them. These are the poll-until-idle ordering, write enable before each erase, opcode and address sequences for both unit sizes, the erase count, refusal of misaligned ranges and the poll timeout. The bench shows them against a behavioural flash model over a sweep of start units, lengths and both unit modes.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_CMD  = 2'd2,
        ST_FIN  = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        CK_STAT  = 2'd0,
        CK_WEN   = 2'd1,
        CK_ERASE = 2'd2
    } cmd_kind_e;

    localparam logic [7:0] OP_STATUS   = 8'h05;
    localparam logic [7:0] OP_WR_EN    = 8'h06;
    localparam logic [7:0] OP_ERASE_4K = 8'h20;
    localparam logic [7:0] OP_ERASE_LG = 8'hD8;

    localparam int SMALL_LOG2 = 12;

    // index of the final byte of each command
    function automatic logic [1:0] final_byte(input cmd_kind_e k);
        case (k)
            CK_STAT:  final_byte = 2'd1;
            CK_WEN:   final_byte = 2'd0;
            default:  final_byte = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/nor_unit_sel.sv
module nor_unit_sel
    import nor_erase_pkg::*;
#(
    parameter int LEN_W      = 25,
    parameter int LARGE_LOG2 = 16
) (
    input  logic             small_i,
    input  logic [23:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [7:0]       op_o,
    output logic [LEN_W-1:0] unit_o,
    output logic             misaligned_o
);

    localparam logic [LEN_W-1:0] SMALL_UNIT = LEN_W'(1) << SMALL_LOG2;
    localparam logic [LEN_W-1:0] LARGE_UNIT = LEN_W'(1) << LARGE_LOG2;

    logic [LEN_W-1:0] mask;
    logic [LEN_W-1:0] addr_ext;

    always_comb begin
        op_o     = small_i ? OP_ERASE_4K : OP_ERASE_LG;
        unit_o   = small_i ? SMALL_UNIT  : LARGE_UNIT;
        mask     = unit_o - LEN_W'(1);
        addr_ext = LEN_W'(addr_i);
        misaligned_o = ((addr_ext & mask) != '0) || ((len_i & mask) != '0);
    end

endmodule

// File: rtl/nor_spi_byte.sv
module nor_spi_byte #(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(SCLK_HALF - 1);

    typedef struct packed {
        logic          act;
        logic          sclk;
        logic [2:0]    bitn;
        logic [CW-1:0] cnt;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.act) begin
            if (go_i) begin
                eng_d.act  = 1'b1;
                eng_d.sclk = 1'b0;
                eng_d.bitn = '0;
                eng_d.cnt  = '0;
                eng_d.sh   = tx_i;
            end
        end else if (eng_q.cnt == CNT_TOP) begin
            eng_d.cnt  = '0;
            eng_d.sclk = !eng_q.sclk;
            if (!eng_q.sclk) begin
                // rising edge: capture the incoming bit
                eng_d.rx = {eng_q.rx[6:0], miso_i};
            end else if (eng_q.bitn == 3'd7) begin
                eng_d.act  = 1'b0;
                eng_d.done = 1'b1;
            end else begin
                // falling edge: present the next bit
                eng_d.bitn = eng_q.bitn + 3'd1;
                eng_d.sh   = {eng_q.sh[6:0], 1'b0};
            end
        end else begin
            eng_d.cnt = eng_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sclk_o = eng_q.sclk;
    assign mosi_o = eng_q.sh[7];
    assign done_o = eng_q.done;
    assign rx_o   = eng_q.rx;

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int LEN_W      = 25,
    parameter int LARGE_LOG2 = 16,
    parameter int SCLK_HALF  = 2,
    parameter int TMO_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [23:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             small_i,
    input  logic [TMO_W-1:0] poll_limit_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i,
    output logic             cs_n_o
);

    typedef struct packed {
        seq_st_e          st;
        cmd_kind_e        kind;
        logic [1:0]       idx;
        logic [23:0]      addr;
        logic [LEN_W-1:0] remain;
        logic [LEN_W-1:0] unit;
        logic [7:0]       op;
        logic [TMO_W-1:0] polls;
        logic             cs_n;
        logic             go;
        logic             err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [7:0]       sel_op;
    logic [LEN_W-1:0] sel_unit;
    logic             sel_bad;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             byte_done;
    logic [TMO_W:0]   poll_next;

    nor_unit_sel #(
        .LEN_W      (LEN_W),
        .LARGE_LOG2 (LARGE_LOG2)
    ) u_sel (
        .small_i      (small_i),
        .addr_i       (addr_i),
        .len_i        (len_i),
        .op_o         (sel_op),
        .unit_o       (sel_unit),
        .misaligned_o (sel_bad)
    );

    nor_spi_byte #(
        .SCLK_HALF (SCLK_HALF)
    ) u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (seq_q.go),
        .tx_i   (tx_byte),
        .miso_i (miso_i),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .done_o (byte_done),
        .rx_o   (rx_byte)
    );

    // byte to shift for the current command position
    always_comb begin
        case (seq_q.kind)
            CK_STAT: tx_byte = (seq_q.idx == 2'd0) ? OP_STATUS : 8'h00;
            CK_WEN:  tx_byte = OP_WR_EN;
            default: begin
                case (seq_q.idx)
                    2'd0:    tx_byte = seq_q.op;
                    2'd1:    tx_byte = seq_q.addr[23:16];
                    2'd2:    tx_byte = seq_q.addr[15:8];
                    default: tx_byte = seq_q.addr[7:0];
                endcase
            end
        endcase
    end

    assign poll_next = {1'b0, seq_q.polls} + (TMO_W + 1)'(1);

    always_comb begin
        seq_d    = seq_q;
        seq_d.go = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.op     = sel_op;
                    seq_d.unit   = sel_unit;
                    seq_d.addr   = addr_i;
                    seq_d.remain = len_i;
                    seq_d.polls  = '0;
                    seq_d.err    = 1'b0;
                    seq_d.kind   = CK_STAT;
                    if (sel_bad) begin
                        seq_d.err = 1'b1;
                        seq_d.st  = ST_FIN;
                    end else if (len_i == '0) begin
                        seq_d.st = ST_FIN;
                    end else begin
                        seq_d.st = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                seq_d.st   = ST_CMD;
                seq_d.cs_n = 1'b0;
                seq_d.idx  = '0;
                seq_d.go   = 1'b1;
            end
            ST_CMD: begin
                if (byte_done) begin
                    if (seq_q.idx != final_byte(seq_q.kind)) begin
                        seq_d.idx = seq_q.idx + 2'd1;
                        seq_d.go  = 1'b1;
                    end else begin
                        seq_d.cs_n = 1'b1;
                        seq_d.st   = ST_GAP;
                        case (seq_q.kind)
                            CK_STAT: begin
                                if (rx_byte[0]) begin
                                    if (poll_next >= {1'b0, poll_limit_i}) begin
                                        seq_d.err = 1'b1;
                                        seq_d.st  = ST_FIN;
                                    end else begin
                                        seq_d.polls = poll_next[TMO_W-1:0];
                                    end
                                end else begin
                                    seq_d.polls = '0;
                                    if (seq_q.remain == '0) seq_d.st = ST_FIN;
                                    else                    seq_d.kind = CK_WEN;
                                end
                            end
                            CK_WEN: seq_d.kind = CK_ERASE;
                            default: begin
                                seq_d.addr   = seq_q.addr + seq_q.unit[23:0];
                                seq_d.remain = seq_q.remain - seq_q.unit;
                                seq_d.kind   = CK_STAT;
                            end
                        endcase
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.st != ST_IDLE);
    assign done_o = (seq_q.st == ST_FIN);
    assign err_o  = (seq_q.st == ST_FIN) && seq_q.err;
    assign cs_n_o = seq_q.cs_n;

endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);

    // R7
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R7
    cs_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o != $past(cs_n_o)) |-> (!sclk_o && !$past(sclk_o)));

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R11
    cs_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

endmodule

bind nor_erase_seq nor_erase_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_o (cs_n_o),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .err_o  (err_o)
);

// File: tb/tb_nor_erase_seq.sv
module tb_nor_erase_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 25;
    localparam int LARGE_LOG2 = 14;
    localparam int BUSY_AFTER = 2;
    localparam int LOG_MAX    = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [23:0]      addr_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic             small_i = 1'b0;
    logic [15:0]      poll_limit_i = 16'd100;
    logic             busy_o, done_o, err_o, sclk_o, mosi_o, cs_n_o;
    logic             miso_i = 1'b0;

    int checks = 0;
    int errs   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_erase_seq #(
        .LEN_W      (LEN_W),
        .LARGE_LOG2 (LARGE_LOG2),
        .SCLK_HALF  (2),
        .TMO_W      (16)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .addr_i       (addr_i),
        .len_i        (len_i),
        .small_i      (small_i),
        .poll_limit_i (poll_limit_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .sclk_o       (sclk_o),
        .mosi_o       (mosi_o),
        .miso_i       (miso_i),
        .cs_n_o       (cs_n_o)
    );

    // ---------------- behavioural flash model (single process) ----------------
    int          preset_val = 0;
    logic        preset_tog = 1'b0;
    logic        tog_seen = 1'b0;
    logic        cs_prev = 1'b1;
    logic        sclk_prev = 1'b0;
    int          busy_left = 0;
    logic        wel = 1'b0;
    int          bitcnt = 0;
    int          nbytes = 0;
    logic [7:0]  cur = '0;
    logic [7:0]  fb [0:7];
    logic [7:0]  stat;
    int          n_stat = 0, n_wen = 0, n_erase = 0, n_csfall = 0;
    int          bad_order = 0, bad_frame = 0;
    logic [7:0]  op_log   [0:LOG_MAX-1];
    logic [23:0] addr_log [0:LOG_MAX-1];

    always @(cs_n_o or sclk_o or preset_tog) begin
        if (preset_tog !== tog_seen) begin
            tog_seen  = preset_tog;
            busy_left = preset_val;
            wel       = 1'b0;
        end
        if (cs_n_o !== cs_prev) begin
            if (cs_n_o === 1'b0) begin
                bitcnt = 0;
                nbytes = 0;
                n_csfall++;
            end else if (cs_prev === 1'b0) begin
                if (bitcnt != nbytes * 8 || nbytes == 0) bad_frame++;
                else begin
                    case (fb[0])
                        8'h05: begin
                            if (nbytes != 2) bad_frame++;
                            n_stat++;
                            if (busy_left > 0) busy_left--;
                        end
                        8'h06: begin
                            if (nbytes != 1) bad_frame++;
                            n_wen++;
                            wel = 1'b1;
                        end
                        8'h20, 8'hD8: begin
                            if (nbytes != 4) bad_frame++;
                            if (busy_left > 0 || !wel) bad_order++;
                            if (n_erase < LOG_MAX) begin
                                op_log[n_erase]   = fb[0];
                                addr_log[n_erase] = {fb[1], fb[2], fb[3]};
                            end
                            n_erase++;
                            wel       = 1'b0;
                            busy_left = BUSY_AFTER;
                        end
                        default: bad_frame++;
                    endcase
                end
            end
            cs_prev = cs_n_o;
        end
        if (sclk_o !== sclk_prev) begin
            if (cs_n_o === 1'b0) begin
                if (sclk_o === 1'b1) begin
                    cur = {cur[6:0], mosi_o};
                    bitcnt++;
                    if (bitcnt % 8 == 0) begin
                        if (nbytes < 8) fb[nbytes] = cur;
                        nbytes++;
                    end
                end else if (nbytes >= 1 && fb[0] == 8'h05 && bitcnt >= 8 && bitcnt < 16) begin
                    stat   = {6'b0, wel, (busy_left > 0)};
                    miso_i = stat[15 - bitcnt];
                end
            end
            sclk_prev = sclk_o;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] a, input logic [LEN_W-1:0] l,
                       input logic sm, input logic [15:0] lim, input int pre,
                       input logic exp_err, input int exp_n, input int exp_stat,
                       input bit poke, input string req);
        int   b_stat, b_wen, b_er, b_cs, b_ord, b_frm;
        int   unit;
        logic got_err;
        bit   seen;
        b_stat = n_stat; b_wen = n_wen; b_er = n_erase;
        b_cs = n_csfall; b_ord = bad_order; b_frm = bad_frame;
        unit = sm ? 4096 : (1 << LARGE_LOG2);
        preset_val = pre;
        preset_tog = ~preset_tog;
        @(negedge clk);
        addr_i = a; len_i = l; small_i = sm; poll_limit_i = lim;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
        seen = 0;
        got_err = 1'b0;
        for (int cyc = 0; cyc < 40000 && !seen; cyc++) begin
            if (done_o) begin
                seen = 1;
                got_err = err_o;
            end else begin
                // R11: a second start while busy must be ignored
                if (poke && cyc == 40) begin
                    start_i = 1'b1;
                    addr_i  = 24'h7F0000;
                    len_i   = LEN_W'(4 * unit);
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(seen, "R11", {req, " done seen"}, seen, 1);
        chk(got_err == exp_err, req, "error flag", got_err, exp_err);
        chk(n_erase - b_er == exp_n, "R6", "erase count", n_erase - b_er, exp_n);
        chk(n_wen - b_wen == exp_n, "R2", "write enable count", n_wen - b_wen, exp_n);
        chk(n_stat - b_stat == exp_stat, "R1", "status read count", n_stat - b_stat, exp_stat);
        chk(bad_order == b_ord, "R1", "erase while busy or without write enable",
            bad_order - b_ord, 0);
        chk(bad_frame == b_frm, "R5", "malformed frame", bad_frame - b_frm, 0);
        if (exp_stat == 0)
            chk(n_csfall == b_cs, "R9", "chip select activity", n_csfall - b_cs, 0);
        for (int k = 0; k < exp_n; k++) begin
            if (b_er + k < LOG_MAX) begin
                chk(op_log[b_er + k] == (sm ? 8'h20 : 8'hD8), sm ? "R3" : "R4",
                    "erase opcode", op_log[b_er + k], sm ? 8'h20 : 8'hD8);
                chk(addr_log[b_er + k] == 24'(a + k * unit), "R6", "erase address",
                    addr_log[b_er + k], 24'(a + k * unit));
            end
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R11", "idle after done", {done_o, busy_o}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errs++;
        checks++;
        $display("FAIL R11 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R8", "bus idle after reset",
            {cs_n_o, sclk_o}, 2'b10);
        chk(!busy_o && !done_o && !err_o, "R11", "handshake idle after reset",
            {busy_o, done_o, err_o}, 0);

        // sweep: both unit modes, start unit 0..2, length 0..3 units (R3 R4 R6)
        for (int sm = 0; sm < 2; sm++) begin
            for (int k = 0; k < 3; k++) begin
                for (int n = 0; n < 4; n++) begin
                    int u;
                    u = (sm != 0) ? 4096 : (1 << LARGE_LOG2);
                    run(24'(k * u), LEN_W'(n * u), sm[0], 16'd100, 1, 1'b0, n,
                        (n == 0) ? 0 : (2 + n * (BUSY_AFTER + 1)), 1'b0,
                        (sm != 0) ? "R3" : "R4");
                end
            end
        end

        // top of the address space, MSB first framing (R5)
        run(24'hFFF000, LEN_W'(4096), 1'b1, 16'd100, 0, 1'b0, 1, 1 + (BUSY_AFTER + 1), 1'b0, "R5");
        run(24'hFF8000, LEN_W'(2 << LARGE_LOG2), 1'b0, 16'd100, 0, 1'b0, 2,
            1 + 2 * (BUSY_AFTER + 1), 1'b0, "R5");

        // misaligned ranges are refused with no bus traffic (R9)
        run(24'h000100, LEN_W'(4096), 1'b1, 16'd100, 0, 1'b1, 0, 0, 1'b0, "R9");
        run(24'h000000, LEN_W'(100),  1'b1, 16'd100, 0, 1'b1, 0, 0, 1'b0, "R9");
        run(24'h001000, LEN_W'(1 << LARGE_LOG2), 1'b0, 16'd100, 0, 1'b1, 0, 0, 1'b0, "R9");
        run(24'h000000, LEN_W'(8192), 1'b0, 16'd100, 0, 1'b1, 0, 0, 1'b0, "R9");

        // poll timeout (R10) and a long busy that stays under the limit (R1)
        run(24'h000000, LEN_W'(4096), 1'b1, 16'd3, 10, 1'b1, 0, 3, 1'b0, "R10");
        run(24'h000000, LEN_W'(4096), 1'b1, 16'd0, 10, 1'b1, 0, 1, 1'b0, "R10");
        run(24'h002000, LEN_W'(4096), 1'b1, 16'd8, 5, 1'b0, 1, 6 + (BUSY_AFTER + 1), 1'b0, "R1");

        // start pulse while busy is ignored (R11)
        run(24'h004000, LEN_W'(2 << LARGE_LOG2), 1'b0, 16'd100, 0, 1'b0, 2,
            1 + 2 * (BUSY_AFTER + 1), 1'b1, "R11");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule